// File: doc/BRIEF.md
# Dual-Lane Saturating SIMD Adder

This block adds or subtracts two 32-bit operand words in one registered step. It works either on the whole word as a single 32-bit lane, or on the word as two independent 16-bit lanes. Bits 31:16 form the high lane and bits 15:0 form the low lane. Each lane has its own add/subtract select, so one lane can subtract while the other adds. A saturation control chooses between clamping a result at the signed limits and letting it wrap in two's complement.

A second unit, `res1`, can be switched on with `pair_en`. It sees the same two operands and has its own add/subtract selects, so a single command returns two words. For example, one word can hold the lane sums and the other the lane differences. Each unit reports a signed-overflow flag. Each unit also has a sticky copy of that flag, which accumulates overflows until it is cleared. Every lane reports an unsigned carry.

All results and flags appear one clock after a command is accepted. They hold their values while no command is given.

Top module: `simd_sat_adder`

## Requirements
- R1: After reset, `res_valid`, `res0`, `res1`, `ovf`, `ovf_sticky` and `carry` are all zero.
- R2: With `split`=0, `res0` is `opa+opb` when `sub0_lo`=0 and `opa-opb` when `sub0_lo`=1, taken over the full 32 bits. In this mode `sub0_hi` is ignored.
- R3: With `split`=1, `res0[31:16]` is computed from the high halves using `sub0_hi`, and `res0[15:0]` from the low halves using `sub0_lo`. Neither lane carries into or affects the other.
- R4: With `pair_en`=1, `res1` is formed from the same operands by the same rules, using `sub1_hi` and `sub1_lo`. With `pair_en`=0, `res1`, `ovf[1]` and `carry[3:2]` are zero.
- R5: With `sat_en`=1, a 16-bit lane that overflows returns 0x7FFF on positive overflow and 0x8000 on negative overflow.
- R6: With `sat_en`=1, a 32-bit result that overflows returns 0x7FFFFFFF or 0x80000000.
- R7: With `sat_en`=0, an overflowing result keeps the low bits of the true result (wraparound), and the overflow flag is still set.
- R8: `ovf[u]` is set when the true signed result of any lane of unit u falls outside the signed range of that lane. Add overflows only when the operand signs are equal. Subtract overflows only when the operand signs differ.
- R9: `carry` bit 0 is unit 0's low lane (or its 32-bit word), bit 1 is unit 0's high lane, bit 2 is unit 1's low lane (or word), and bit 3 is unit 1's high lane. On add, a carry bit is set when the unsigned sum exceeds the lane width. On subtract, it is set when the minuend is not smaller than the subtrahend, unsigned. High-lane bits are zero when `split`=0.
- R10: `ovf_sticky[u]` is ORed with each new `ovf[u]`. It clears only when `flag_clr` is high. An overflow from a command in the same cycle as the clear survives the clear.
- R11: `res_valid` is `cmd_valid` delayed by one clock. Results, `ovf` and `carry` change only in the cycle after a command and otherwise hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| split | input | 1 | 1: two 16-bit lanes, 0: one 32-bit lane |
| pair_en | input | 1 | Enables the second result unit |
| sat_en | input | 1 | 1: saturate, 0: wrap |
| sub0_hi | input | 1 | Unit 0 high-lane subtract |
| sub0_lo | input | 1 | Unit 0 low-lane (or word) subtract |
| sub1_hi | input | 1 | Unit 1 high-lane subtract |
| sub1_lo | input | 1 | Unit 1 low-lane (or word) subtract |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| flag_clr | input | 1 | Clears the sticky overflow flags |
| res_valid | output | 1 | Result strobe |
| res0 | output | 32 | Unit 0 result |
| res1 | output | 32 | Unit 1 result |
| ovf | output | 2 | Overflow per unit |
| ovf_sticky | output | 2 | Sticky overflow per unit |
| carry | output | 4 | Carry per lane |

## Verification
The sticky-flag clear and a new overflow can fall in the same clock edge. This collision is provoked with directed commands that assert `flag_clr` together with an overflowing operation. A clear with no command is also tried, as is a clear paired with a command that does not overflow. Each outcome is judged against a bench model of the flags: clear first, then OR in the new overflow. Random commands then mix `flag_clr` in at a low rate, so the collision also occurs with random mode and lane-select combinations.

// File: rtl/simd_sat_adder.sv
module simd_sat_adder #(
  parameter int LANE_W = 16,
  localparam int WORD_W = 2 * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              split,
  input  logic              pair_en,
  input  logic              sat_en,
  input  logic              sub0_hi,
  input  logic              sub0_lo,
  input  logic              sub1_hi,
  input  logic              sub1_lo,
  input  logic [WORD_W-1:0] opa,
  input  logic [WORD_W-1:0] opb,
  input  logic              flag_clr,
  output logic              res_valid,
  output logic [WORD_W-1:0] res0,
  output logic [WORD_W-1:0] res1,
  output logic [1:0]        ovf,
  output logic [1:0]        ovf_sticky,
  output logic [3:0]        carry
);
  localparam int NUM_UNITS = 2;

  function automatic logic [LANE_W+1:0] lane_op(input logic [LANE_W-1:0] x, y,
                                                input logic sub, sat);
    logic [LANE_W-1:0] yy, r;
    logic [LANE_W:0]   s;
    logic              v;
    yy = sub ? ~y : y;
    s  = {1'b0, x} + {1'b0, yy} + {{LANE_W{1'b0}}, sub};
    v  = (x[LANE_W-1] == yy[LANE_W-1]) && (s[LANE_W-1] != x[LANE_W-1]);
    if (v && sat) r = x[LANE_W-1] ? {1'b1, {(LANE_W-1){1'b0}}} : {1'b0, {(LANE_W-1){1'b1}}};
    else          r = s[LANE_W-1:0];
    return {v, s[LANE_W], r};
  endfunction

  function automatic logic [WORD_W+1:0] word_op(input logic [WORD_W-1:0] x, y,
                                                input logic sub, sat);
    logic [WORD_W-1:0] yy, r;
    logic [WORD_W:0]   s;
    logic              v;
    yy = sub ? ~y : y;
    s  = {1'b0, x} + {1'b0, yy} + {{WORD_W{1'b0}}, sub};
    v  = (x[WORD_W-1] == yy[WORD_W-1]) && (s[WORD_W-1] != x[WORD_W-1]);
    if (v && sat) r = x[WORD_W-1] ? {1'b1, {(WORD_W-1){1'b0}}} : {1'b0, {(WORD_W-1){1'b1}}};
    else          r = s[WORD_W-1:0];
    return {v, s[WORD_W], r};
  endfunction

  logic [NUM_UNITS-1:0]   sel_hi, sel_lo;
  logic [WORD_W-1:0]      nxt_res [NUM_UNITS];
  logic [NUM_UNITS-1:0]   nxt_ovf;
  logic [2*NUM_UNITS-1:0] nxt_carry;

  assign sel_hi = {sub1_hi, sub0_hi};
  assign sel_lo = {sub1_lo, sub0_lo};

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic [LANE_W+1:0] hi_r, lo_r;
    logic [WORD_W+1:0] w_r;
    logic              en;

    assign en   = (u == 0) || pair_en;
    assign hi_r = lane_op(opa[WORD_W-1:LANE_W], opb[WORD_W-1:LANE_W], sel_hi[u], sat_en);
    assign lo_r = lane_op(opa[LANE_W-1:0], opb[LANE_W-1:0], sel_lo[u], sat_en);
    assign w_r  = word_op(opa, opb, sel_lo[u], sat_en);

    assign nxt_res[u]       = !en  ? '0 :
                              split ? {hi_r[LANE_W-1:0], lo_r[LANE_W-1:0]} : w_r[WORD_W-1:0];
    assign nxt_ovf[u]       = en && (split ? (hi_r[LANE_W+1] || lo_r[LANE_W+1]) : w_r[WORD_W+1]);
    assign nxt_carry[2*u]   = en && (split ? lo_r[LANE_W] : w_r[WORD_W]);
    assign nxt_carry[2*u+1] = en && split && hi_r[LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res0       <= '0;
      res1       <= '0;
      ovf        <= '0;
      carry      <= '0;
      ovf_sticky <= '0;
    end else begin
      res_valid  <= cmd_valid;
      if (cmd_valid) begin
        res0  <= nxt_res[0];
        res1  <= nxt_res[1];
        ovf   <= nxt_ovf;
        carry <= nxt_carry;
      end
      ovf_sticky <= (flag_clr ? 2'b00 : ovf_sticky) | (cmd_valid ? nxt_ovf : 2'b00);
    end
  end
endmodule

// File: rtl/simd_sat_adder_chk.sv
module simd_sat_adder_chk #(
  parameter int LANE_W = 16,
  localparam int WORD_W = 2 * LANE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              split,
  input logic              pair_en,
  input logic              sat_en,
  input logic              flag_clr,
  input logic              res_valid,
  input logic [WORD_W-1:0] res0,
  input logic [WORD_W-1:0] res1,
  input logic [1:0]        ovf,
  input logic [1:0]        ovf_sticky,
  input logic [3:0]        carry
);
  localparam logic [WORD_W-1:0] W_MAX = {1'b0, {(WORD_W-1){1'b1}}};
  localparam logic [WORD_W-1:0] W_MIN = {1'b1, {(WORD_W-1){1'b0}}};

  assert_valid_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> res_valid);

  assert_idle_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> (!res_valid && $stable(res0) && $stable(res1) && $stable(ovf) && $stable(carry)));

  assert_second_unit_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !pair_en) |=> (res1 == '0 && !ovf[1] && carry[3:2] == 2'b00));

  assert_word_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && sat_en && !split) |=> (!ovf[0] || res0 == W_MAX || res0 == W_MIN));

  assert_no_hi_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !split) |=> (!carry[1] && !carry[3]));

  assert_sticky_covers_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((ovf & ~ovf_sticky) == 2'b00));

  assert_sticky_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_clr |=> ((ovf_sticky & $past(ovf_sticky)) == $past(ovf_sticky)));
endmodule

bind simd_sat_adder simd_sat_adder_chk #(.LANE_W(LANE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .split(split), .pair_en(pair_en),
  .sat_en(sat_en), .flag_clr(flag_clr), .res_valid(res_valid), .res0(res0), .res1(res1),
  .ovf(ovf), .ovf_sticky(ovf_sticky), .carry(carry)
);

// File: tb/simd_sat_adder_tb_top.sv
module simd_sat_adder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 0, split = 0, pair_en = 0, sat_en = 0;
  logic        sub0_hi = 0, sub0_lo = 0, sub1_hi = 0, sub1_lo = 0, flag_clr = 0;
  logic [31:0] opa = 0, opb = 0;
  logic        res_valid;
  logic [31:0] res0, res1;
  logic [1:0]  ovf, ovf_sticky;
  logic [3:0]  carry;

  int checks = 0, errors = 0;
  logic [31:0] e_res0 = 0, e_res1 = 0;
  logic [1:0]  e_ovf = 0, e_stk = 0;
  logic [3:0]  e_carry = 0;

  always #4 clk = ~clk;

  simd_sat_adder dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .split(split), .pair_en(pair_en),
    .sat_en(sat_en), .sub0_hi(sub0_hi), .sub0_lo(sub0_lo), .sub1_hi(sub1_hi), .sub1_lo(sub1_lo),
    .opa(opa), .opb(opb), .flag_clr(flag_clr), .res_valid(res_valid), .res0(res0), .res1(res1),
    .ovf(ovf), .ovf_sticky(ovf_sticky), .carry(carry)
  );

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // {ov, carry, result}
  function automatic logic [17:0] ref16(input logic [15:0] a, b, input logic sub, sat);
    int s, ua, ub;
    logic ov, c;
    logic [15:0] r;
    s  = sub ? ($signed(a) - $signed(b)) : ($signed(a) + $signed(b));
    ua = int'(a);
    ub = int'(b);
    ov = (s > 32767) || (s < -32768);
    c  = sub ? (ua >= ub) : (ua + ub > 65535);
    r  = (ov && sat) ? ((s > 0) ? 16'h7FFF : 16'h8000) : s[15:0];
    return {ov, c, r};
  endfunction

  function automatic logic [33:0] ref32(input logic [31:0] a, b, input logic sub, sat);
    longint s, ua, ub;
    logic ov, c;
    logic [31:0] r;
    s  = sub ? (longint'($signed(a)) - longint'($signed(b))) : (longint'($signed(a)) + longint'($signed(b)));
    ua = longint'({32'b0, a});
    ub = longint'({32'b0, b});
    ov = (s > 64'sd2147483647) || (s < -64'sd2147483648);
    c  = sub ? (ua >= ub) : (ua + ub > 64'sd4294967295);
    r  = (ov && sat) ? ((s > 0) ? 32'h7FFFFFFF : 32'h80000000) : s[31:0];
    return {ov, c, r};
  endfunction

  // {ov, carry_hi, carry_lo, result}
  function automatic logic [34:0] ref_unit(input logic [31:0] a, b, input logic sp, shi, slo, sat);
    logic [17:0] h, l;
    logic [33:0] w;
    h = ref16(a[31:16], b[31:16], shi, sat);
    l = ref16(a[15:0], b[15:0], slo, sat);
    w = ref32(a, b, slo, sat);
    if (sp) return {h[17] | l[17], h[16], l[16], h[15:0], l[15:0]};
    return {w[33], 1'b0, w[32], w[31:0]};
  endfunction

  task automatic issue(input logic v, sp, pe, sat, s0h, s0l, s1h, s1l,
                       input logic [31:0] a, b, input logic clr, input string req);
    logic [34:0] u0, u1;
    cmd_valid = v; split = sp; pair_en = pe; sat_en = sat;
    sub0_hi = s0h; sub0_lo = s0l; sub1_hi = s1h; sub1_lo = s1l;
    opa = a; opb = b; flag_clr = clr;
    u0 = ref_unit(a, b, sp, s0h, s0l, sat);
    u1 = pe ? ref_unit(a, b, sp, s1h, s1l, sat) : 35'd0;
    if (clr) e_stk = 2'b00;
    if (v) begin
      e_res0  = u0[31:0];
      e_res1  = u1[31:0];
      e_ovf   = {u1[34], u0[34]};
      e_carry = {u1[33], u1[32], u0[33], u0[32]};
      e_stk   = e_stk | e_ovf;
    end
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0; flag_clr = 0;
    check("R11", "res_valid", 64'(res_valid), 64'(v));
    check(sp ? "R3" : "R2", "res0", 64'(res0), 64'(e_res0));
    check("R4", "res1", 64'(res1), 64'(e_res1));
    check("R8", "ovf", 64'(ovf), 64'(e_ovf));
    check("R9", "carry", 64'(carry), 64'(e_carry));
    check("R10", "ovf_sticky", 64'(ovf_sticky), 64'(e_stk));
    if (req != "") check(req, "directed res0", 64'(res0), 64'(e_res0));
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R11 actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    process::self().srandom(32'd20240611);
    repeat (3) @(negedge clk);
    check("R1", "reset res_valid", 64'(res_valid), 0);
    check("R1", "reset res0", 64'(res0), 0);
    check("R1", "reset res1", 64'(res1), 0);
    check("R1", "reset flags", 64'({ovf, ovf_sticky, carry}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6: positive and negative word clamp
    issue(1, 0, 0, 1, 0, 0, 0, 0, 32'h7FFFFFFF, 32'h00000001, 0, "R6");
    check("R6", "clamp max", 64'(res0), 64'h7FFFFFFF);
    issue(1, 0, 0, 1, 0, 1, 0, 0, 32'h80000000, 32'h00000001, 0, "R6");
    check("R6", "clamp min", 64'(res0), 64'h80000000);
    // R7: wrap with flag
    issue(1, 0, 0, 0, 0, 0, 0, 0, 32'h7FFFFFFF, 32'h00000001, 1, "R7");
    check("R7", "wrap", 64'(res0), 64'h80000000);
    check("R7", "wrap ovf", 64'(ovf[0]), 1);
    // R3 and R5: high lane adds and clamps, low lane subtracts and clamps low
    issue(1, 1, 0, 1, 0, 1, 0, 0, 32'h7FFF8000, 32'h00010001, 0, "R5");
    check("R5", "lane clamps", 64'(res0), 64'h7FFF8000);
    issue(1, 1, 0, 0, 0, 1, 0, 0, 32'h12340005, 32'h11110007, 0, "R3");
    check("R3", "independent lanes", 64'(res0), 64'h2345FFFE);
    check("R9", "borrow lane", 64'(carry), 64'h0);
    // R9: subtract carry when minuend not smaller, add carry out
    issue(1, 1, 0, 0, 0, 1, 0, 0, 32'hFFFF0009, 32'h00010009, 0, "R9");
    check("R9", "carry hi add, lo sub equal", 64'(carry), 64'h3);
    // R4: pair mode sums and differences
    issue(1, 1, 1, 1, 0, 0, 1, 1, 32'h00100020, 32'h00030004, 0, "R4");
    check("R4", "sums", 64'(res0), 64'h00130024);
    check("R4", "diffs", 64'(res1), 64'h000D001C);
    // R11: idle holds
    issue(0, 0, 0, 0, 1, 1, 1, 1, 32'h1, 32'h2, 0, "R11");
    check("R11", "hold", 64'(res1), 64'h000D001C);
    // R10: clear with simultaneous overflow, clear alone
    issue(1, 0, 1, 0, 0, 0, 0, 1, 32'h40000000, 32'h40000000, 0, "R10");
    issue(1, 0, 1, 0, 0, 0, 1, 1, 32'h40000000, 32'h40000000, 1, "R10");
    check("R10", "survive clear", 64'(ovf_sticky), 64'h1);
    issue(0, 0, 0, 0, 0, 0, 0, 0, 32'h0, 32'h0, 1, "R10");
    check("R10", "cleared", 64'(ovf_sticky), 64'h0);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b;
      logic [3:0] pick;
      pick = 4'($urandom_range(0, 15));
      a = $urandom;
      b = $urandom;
      if (pick[0]) a[31:30] = 2'b01;
      if (pick[1]) b[15:14] = 2'b10;
      if (pick == 4'hF) b = a;
      issue(1'($urandom_range(0, 9) != 0), 1'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), a, b,
            1'($urandom_range(0, 7) == 0), "");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule